// File: doc/BRIEF.md
# Dual-Order Display Memory Write Pointer

This block produces the write address for a graphic display memory organised as a small number of banks, each holding one byte per column. With the default sizing there are 5 banks of 101 columns, which gives 505 bytes. A command interface loads a starting bank and column together with a walk-order bit. Each byte write strobe then moves the pointer one step in the chosen order. The block presents the current bank, the current column and a flat memory address that the memory array can use directly.

The pointer has two walk orders. In row order it steps across the columns of one bank and then carries into the next bank. In column order it steps down through the banks at a fixed column and then carries into the next column. Because neither dimension is a power of two, both orders need explicit end-of-range carries. At the final cell, both orders return to bank 0, column 0.

Top module: `disp_wr_pointer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the bank and column to 0 and selects row order. A write issued after reset, with no load, therefore moves the column from 0 to 1.
- R2: When `load_i` is high and both fields are in range, the bank and column take the values of `load_y_i` and `load_x_i` at the next edge. The order bit is taken from `mode_i` at the same edge (0 = row order, 1 = column order).
- R3: At a load, a bank value above NUM_BANKS-1 is replaced by 0. Independently, a column value above NUM_COLS-1 is replaced by 0.
- R4: In row order, a write whose column is below NUM_COLS-1 increments the column and leaves the bank unchanged.
- R5: In row order, a write at column NUM_COLS-1 sets the column to 0 and increments the bank.
- R6: In column order, a write whose bank is below NUM_BANKS-1 increments the bank and leaves the column unchanged.
- R7: In column order, a write at bank NUM_BANKS-1 sets the bank to 0 and increments the column.
- R8: In either order, a write at bank NUM_BANKS-1 and column NUM_COLS-1 returns the pointer to bank 0, column 0.
- R9: `addr_o` always equals bank*NUM_COLS + column. As a result, consecutive writes produce step index k = bank*101+column in row order and k = column*5+bank in column order.
- R10: In a cycle with neither a load nor a write, the bank, the column and the address keep their values.
- R11: When a load and a write occur in the same cycle, the load takes effect and the write is ignored.
- R12: The bank output never exceeds NUM_BANKS-1, and the column output never exceeds NUM_COLS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load strobe for the bank, column and order bit |
| load_y_i | input | 3 | Bank value to load |
| load_x_i | input | 7 | Column value to load |
| mode_i | input | 1 | Walk order captured at load: 0 = row order, 1 = column order |
| wr_i | input | 1 | Byte write strobe; advances the pointer |
| y_o | output | 3 | Current bank |
| x_o | output | 7 | Current column |
| addr_o | output | 9 | Flat address, bank*NUM_COLS + column |

## Verification
The bench builds the block with its default sizing of 5 banks by 101 columns. This sizing is deliberate: neither dimension is a power of two, so the end-of-range carries are real comparisons and cannot be handled by natural overflow. It also makes the full 505-step walk in each order short enough to run completely. Every carry and the final wrap are therefore reached at their true boundaries, and the 3-bit and 7-bit load fields can carry the out-of-range values 5 to 7 and 101 to 127 that exercise clamping.

// File: rtl/disp_ptr_pkg.sv
package disp_ptr_pkg;
  typedef enum logic {
    WALK_ROW = 1'b0,
    WALK_COL = 1'b1
  } walk_e;
endpackage

// File: rtl/disp_ptr_clamp.sv
module disp_ptr_clamp #(
  parameter int NUM_BANKS = 5,
  parameter int NUM_COLS  = 101,
  localparam int Y_W = $clog2(NUM_BANKS),
  localparam int X_W = $clog2(NUM_COLS)
) (
  input  logic [Y_W-1:0] raw_y_i,
  input  logic [X_W-1:0] raw_x_i,
  output logic [Y_W-1:0] safe_y_o,
  output logic [X_W-1:0] safe_x_o,
  output logic           y_bad_o,
  output logic           x_bad_o
);
  localparam logic [Y_W-1:0] Y_LAST = Y_W'(NUM_BANKS - 1);
  localparam logic [X_W-1:0] X_LAST = X_W'(NUM_COLS - 1);

  function automatic logic [Y_W-1:0] fix_y(input logic [Y_W-1:0] v);
    return (v > Y_LAST) ? '0 : v;
  endfunction

  function automatic logic [X_W-1:0] fix_x(input logic [X_W-1:0] v);
    return (v > X_LAST) ? '0 : v;
  endfunction

  assign y_bad_o  = raw_y_i > Y_LAST;
  assign x_bad_o  = raw_x_i > X_LAST;
  assign safe_y_o = fix_y(raw_y_i);
  assign safe_x_o = fix_x(raw_x_i);
endmodule

// File: rtl/disp_ptr_step.sv
module disp_ptr_step
  import disp_ptr_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int NUM_COLS  = 101,
  localparam int Y_W = $clog2(NUM_BANKS),
  localparam int X_W = $clog2(NUM_COLS)
) (
  input  walk_e          mode_i,
  input  logic [Y_W-1:0] y_i,
  input  logic [X_W-1:0] x_i,
  output logic [Y_W-1:0] next_y_o,
  output logic [X_W-1:0] next_x_o,
  output logic           bank_end_o,
  output logic           col_end_o,
  output logic           full_wrap_o
);
  localparam logic [Y_W-1:0] Y_LAST = Y_W'(NUM_BANKS - 1);
  localparam logic [X_W-1:0] X_LAST = X_W'(NUM_COLS - 1);

  function automatic logic [Y_W-1:0] bump_y(input logic [Y_W-1:0] v);
    return (v == Y_LAST) ? '0 : v + Y_W'(1);
  endfunction

  function automatic logic [X_W-1:0] bump_x(input logic [X_W-1:0] v);
    return (v == X_LAST) ? '0 : v + X_W'(1);
  endfunction

  assign bank_end_o  = (y_i == Y_LAST);
  assign col_end_o   = (x_i == X_LAST);
  assign full_wrap_o = bank_end_o && col_end_o;

  always_comb begin
    if (mode_i == WALK_ROW) begin
      next_x_o = bump_x(x_i);
      next_y_o = col_end_o ? bump_y(y_i) : y_i;
    end else begin
      next_y_o = bump_y(y_i);
      next_x_o = bank_end_o ? bump_x(x_i) : x_i;
    end
  end
endmodule

// File: rtl/disp_wr_pointer.sv
module disp_wr_pointer
  import disp_ptr_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int NUM_COLS  = 101,
  localparam int Y_W = $clog2(NUM_BANKS),
  localparam int X_W = $clog2(NUM_COLS),
  localparam int A_W = $clog2(NUM_BANKS * NUM_COLS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic [Y_W-1:0] load_y_i,
  input  logic [X_W-1:0] load_x_i,
  input  logic           mode_i,
  input  logic           wr_i,
  output logic [Y_W-1:0] y_o,
  output logic [X_W-1:0] x_o,
  output logic [A_W-1:0] addr_o
);
  localparam logic [Y_W-1:0] Y_LAST = Y_W'(NUM_BANKS - 1);
  localparam logic [X_W-1:0] X_LAST = X_W'(NUM_COLS - 1);
  localparam logic [A_W-1:0] A_LAST = A_W'(NUM_BANKS * NUM_COLS - 1);

  function automatic logic [A_W-1:0] flat_addr(input logic [Y_W-1:0] y,
                                                input logic [X_W-1:0] x);
    return A_W'(y) * A_W'(NUM_COLS) + A_W'(x);
  endfunction

  walk_e          mode_q;
  logic [Y_W-1:0] y_q;
  logic [X_W-1:0] x_q;

  logic [Y_W-1:0] load_y_ok, step_y;
  logic [X_W-1:0] load_x_ok, step_x;
  logic           y_bad, x_bad;
  logic           bank_end, col_end, full_wrap;
  logic           take_load, take_step;

  disp_ptr_clamp #(.NUM_BANKS(NUM_BANKS), .NUM_COLS(NUM_COLS)) u_clamp (
    .raw_y_i (load_y_i),
    .raw_x_i (load_x_i),
    .safe_y_o(load_y_ok),
    .safe_x_o(load_x_ok),
    .y_bad_o (y_bad),
    .x_bad_o (x_bad)
  );

  disp_ptr_step #(.NUM_BANKS(NUM_BANKS), .NUM_COLS(NUM_COLS)) u_step (
    .mode_i     (mode_q),
    .y_i        (y_q),
    .x_i        (x_q),
    .next_y_o   (step_y),
    .next_x_o   (step_x),
    .bank_end_o (bank_end),
    .col_end_o  (col_end),
    .full_wrap_o(full_wrap)
  );

  // load has priority over write (R11)
  assign take_load = load_i;
  assign take_step = wr_i && !load_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q    <= '0;
      x_q    <= '0;
      mode_q <= WALK_ROW;
    end else if (take_load) begin
      y_q    <= load_y_ok;
      x_q    <= load_x_ok;
      mode_q <= walk_e'(mode_i);
    end else if (take_step) begin
      y_q <= step_y;
      x_q <= step_x;
    end
  end

  assign y_o    = y_q;
  assign x_o    = x_q;
  assign addr_o = flat_addr(y_q, x_q);

  p_load_y_r2: assert property (@(posedge clk) disable iff (rst)
    (load_i && !y_bad) |=> (y_o == $past(load_y_i)));
  p_load_x_r2: assert property (@(posedge clk) disable iff (rst)
    (load_i && !x_bad) |=> (x_o == $past(load_x_i)));
  p_clamp_y_r3: assert property (@(posedge clk) disable iff (rst)
    (load_i && y_bad) |=> (y_o == '0));
  p_clamp_x_r3: assert property (@(posedge clk) disable iff (rst)
    (load_i && x_bad) |=> (x_o == '0));
  p_row_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (take_step && mode_q == WALK_ROW) |=>
      (addr_o == (($past(addr_o) == A_LAST) ? '0 : $past(addr_o) + A_W'(1))));
  p_col_down_r6: assert property (@(posedge clk) disable iff (rst)
    (take_step && mode_q == WALK_COL && !bank_end) |=>
      (x_o == $past(x_o) && y_o == $past(y_o) + Y_W'(1)));
  p_col_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (take_step && mode_q == WALK_COL && bank_end && !col_end) |=>
      (y_o == '0 && x_o == $past(x_o) + X_W'(1)));
  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (take_step && full_wrap) |=> (y_o == '0 && x_o == '0));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !wr_i) |=> ($stable(y_o) && $stable(x_o) && $stable(addr_o)));
  p_in_range_r12: assert property (@(posedge clk) disable iff (rst)
    (y_o <= Y_LAST && x_o <= X_LAST));
endmodule

// File: tb/disp_wr_pointer_bench.sv
module disp_wr_pointer_bench;
  localparam int NB = 5;
  localparam int NC = 101;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_i = 1'b0;
  logic [2:0] load_y_i = '0;
  logic [6:0] load_x_i = '0;
  logic       mode_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [2:0] y_o;
  logic [6:0] x_o;
  logic [8:0] addr_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  disp_wr_pointer u_disp_wr_pointer (
    .clk(clk), .rst(rst), .load_i(load_i), .load_y_i(load_y_i),
    .load_x_i(load_x_i), .mode_i(mode_i), .wr_i(wr_i),
    .y_o(y_o), .x_o(x_o), .addr_o(addr_o)
  );

  // vector: {req[3:0], load, mode, ly[2:0], lx[6:0], wr, ey[2:0], ex[6:0]}
  localparam int NV = 21;
  localparam logic [26:0] VEC [NV] = '{
    {4'd2,  1'b1, 1'b0, 3'd2, 7'd50,  1'b0, 3'd2, 7'd50 }, // R2 load
    {4'd4,  1'b0, 1'b0, 3'd0, 7'd0,   1'b1, 3'd2, 7'd51 }, // R4 row step
    {4'd2,  1'b1, 1'b0, 3'd1, 7'd100, 1'b0, 3'd1, 7'd100}, // R2
    {4'd5,  1'b0, 1'b0, 3'd0, 7'd0,   1'b1, 3'd2, 7'd0  }, // R5 bank carry
    {4'd2,  1'b1, 1'b0, 3'd4, 7'd100, 1'b0, 3'd4, 7'd100}, // R2
    {4'd8,  1'b0, 1'b0, 3'd0, 7'd0,   1'b1, 3'd0, 7'd0  }, // R8 row wrap
    {4'd2,  1'b1, 1'b1, 3'd0, 7'd7,   1'b0, 3'd0, 7'd7  }, // R2
    {4'd6,  1'b0, 1'b0, 3'd0, 7'd0,   1'b1, 3'd1, 7'd7  }, // R6 col step
    {4'd2,  1'b1, 1'b1, 3'd4, 7'd33,  1'b0, 3'd4, 7'd33 }, // R2
    {4'd7,  1'b0, 1'b0, 3'd0, 7'd0,   1'b1, 3'd0, 7'd34 }, // R7 column carry
    {4'd2,  1'b1, 1'b1, 3'd4, 7'd100, 1'b0, 3'd4, 7'd100}, // R2
    {4'd8,  1'b0, 1'b0, 3'd0, 7'd0,   1'b1, 3'd0, 7'd0  }, // R8 column wrap
    {4'd6,  1'b0, 1'b0, 3'd0, 7'd0,   1'b1, 3'd1, 7'd0  }, // R6
    {4'd10, 1'b0, 1'b0, 3'd3, 7'd9,   1'b0, 3'd1, 7'd0  }, // R10 idle hold
    {4'd3,  1'b1, 1'b1, 3'd6, 7'd20,  1'b0, 3'd0, 7'd20 }, // R3 bank clamp
    {4'd3,  1'b1, 1'b0, 3'd3, 7'd127, 1'b0, 3'd3, 7'd0  }, // R3 column clamp
    {4'd11, 1'b1, 1'b0, 3'd2, 7'd9,   1'b1, 3'd2, 7'd9  }, // R11 load wins
    {4'd4,  1'b0, 1'b0, 3'd0, 7'd0,   1'b1, 3'd2, 7'd10 }, // R4 mode from load
    {4'd11, 1'b1, 1'b1, 3'd7, 7'd120, 1'b1, 3'd0, 7'd0  }, // R11 + R3
    {4'd6,  1'b0, 1'b0, 3'd0, 7'd0,   1'b1, 3'd1, 7'd0  }, // R6
    {4'd10, 1'b0, 1'b1, 3'd0, 7'd0,   1'b0, 3'd1, 7'd0  }  // R10
  };

  task automatic check(input int req, input int ey, input int ex);
    int ea;
    ea = ey * NC + ex;
    n_run++;
    if (int'(y_o) != ey || int'(x_o) != ex || int'(addr_o) != ea) begin
      n_fail++;
      $display("FAIL R%0d: got y=%0d x=%0d addr=%0d, expected y=%0d x=%0d addr=%0d",
               req, y_o, x_o, addr_o, ey, ex, ea);
    end
  endtask

  task automatic cyc(input logic ld, input logic md, input int ly, input int lx,
                     input logic wr);
    load_i = ld; mode_i = md; load_y_i = 3'(ly); load_x_i = 7'(lx); wr_i = wr;
    @(negedge clk);
    load_i = 1'b0; wr_i = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(1, 0, 0); // R1 reset state

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][22], VEC[i][21], int'(VEC[i][20:18]), int'(VEC[i][17:11]), VEC[i][10]);
      check(int'(VEC[i][26:23]), int'(VEC[i][9:7]), int'(VEC[i][6:0]));
    end

    // R1: reset mid-run restores origin and row order
    cyc(1'b1, 1'b1, 3, 40, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(1, 0, 0);
    cyc(1'b0, 1'b0, 0, 0, 1'b1);
    check(1, 0, 1);

    // R9, R12, R5, R8: full row-order walk, index k = y*101+x
    cyc(1'b1, 1'b0, 0, 0, 1'b0);
    for (int k = 1; k <= NB * NC; k++) begin
      cyc(1'b0, 1'b0, 0, 0, 1'b1);
      check(9, (k % (NB * NC)) / NC, (k % (NB * NC)) % NC);
    end

    // R9, R12, R7, R8: full column-order walk, index k = x*5+y
    cyc(1'b1, 1'b1, 0, 0, 1'b0);
    for (int k = 1; k <= NB * NC; k++) begin
      cyc(1'b0, 1'b0, 0, 0, 1'b1);
      check(9, (k % (NB * NC)) % NB, (k % (NB * NC)) / NB);
    end

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule